// File: doc/BRIEF.md
# Clock Output Divider and Countdown Timer

This block turns a reference tick stream into two timekeeping services that share one prescaler. The first is a square-wave clock output whose rate is chosen among four divisions of a 32768 Hz reference. The output is gated so that enabling it, disabling it or changing its rate never produces a high phase shorter than a full half period. The second is an 8-bit countdown timer. It steps on one of four tick rates, the slowest being one tick per minute. When it expires it raises a timer flag, reloads itself and drives an active-low interrupt line, either as a level or as a pulse.

The reference is delivered as `ref_tick`, a one-cycle strobe in the system clock domain at twice the reference frequency, so one strobe marks each half period of the 32768 Hz wave. Four registers are written and read through a simple address/data port. All register fields are reset to zero.

The clock-gating state machine has three states. In `CO_IDLE` the output is parked low. In `CO_RUN` the output follows the selected rate. `CO_SWAP` holds a pending rate change. Its transitions are:
- idle→run: the output is enabled and the requested wave is low; the requested rate is latched.
- run→swap: the requested rate differs from the one in use.
- swap→run: both the old and the new wave are low; the new rate is latched.
- run→idle and swap→idle: the output is disabled and the wave in use is low.

Top module: `rtcdiv_timer`

## Requirements
- R1: After reset, `clk_out` is 0, `irq_n` is 1, and every readable register returns 0x00.
- R2: Register 0x0D carries the output enable in bit 7 and the rate in bits [1:0]. Rate 0 gives a wave with a half period of 1 strobe (32768 Hz). Rate 1 gives 2^CO_B1 strobes (1024 Hz), rate 2 gives 2^CO_B2 (32 Hz) and rate 3 gives 2^CO_B3 (1 Hz).
- R3: When the enable in 0x0D is cleared, the output finishes its current high phase, then stays low.
- R4: A rate change takes effect only while both the old and new waves are low, so every high phase lasts a full half period of one of the two rates.
- R5: Register 0x0E carries the timer enable in bit 7 and the tick source in bits [1:0]. Source 0 is 4096 Hz (every 2^TM_B0 strobes), 1 is 64 Hz (2^TM_B1), 2 is 1 Hz (2^TM_B2) and 3 is 1/60 Hz (MIN_DIV ticks of source 2).
- R6: Writing N to 0x0F loads both the reload value and the count. Each source tick decrements the count. A tick at a count of 1 or less expires: the count reloads, so expiries repeat every N ticks. Reading 0x0F returns the live count.
- R7: The timer flag is bit 2 of register 0x01 and is set on expiry. A write to 0x01 with bit 2 at 0 clears it, and a write with bit 2 at 1 leaves it unchanged. An expiry wins over a clear in the same cycle.
- R8: With bit 4 of 0x01 at 1 (pulse mode) and bit 0 (interrupt enable) at 1, `irq_n` falls at each expiry and stays low for exactly one source tick period.
- R9: With bit 4 of 0x01 at 0 (level mode), `irq_n` is low exactly while the flag and the interrupt enable are both 1.
- R10: While the timer enable is 0, the count holds and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Half-period strobe of the 32768 Hz reference |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| clk_out | output | 1 | Gated square-wave clock output |
| irq_n | output | 1 | Active-low timer interrupt |

## Verification
A register write takes effect at the next clock edge, and its readback is valid in the cycle that follows. `clk_out` follows its prescaler bit with one register of delay, and `irq_n` changes at the edge on which the expiring tick is registered. The prescaler phase at any stimulus is arbitrary. The bench therefore measures relative quantities: the length of each high run, the distance between successive `irq_n` falling edges, and the width of each low pulse, all counted from samples taken on the falling clock edge. It compares these against the run lengths and periods that the requirements imply for the reduced parameter set.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h1;
    localparam logic [ADDR_W-1:0] A_CLKO = 4'hD;
    localparam logic [ADDR_W-1:0] A_TCTL = 4'hE;
    localparam logic [ADDR_W-1:0] A_TCNT = 4'hF;

    localparam int EN_BIT    = 7;
    localparam int PULSE_BIT = 4;
    localparam int TF_BIT    = 2;
    localparam int TIE_BIT   = 0;

    typedef enum logic [1:0] {
        CO_IDLE,
        CO_RUN,
        CO_SWAP
    } co_state_e;
endpackage

// File: rtl/rtcdiv_prescale.sv
module rtcdiv_prescale #(
    parameter int PRE_W   = 16,
    parameter int CO_B1   = 5,
    parameter int CO_B2   = 10,
    parameter int CO_B3   = 15,
    parameter int TM_B0   = 4,
    parameter int TM_B1   = 10,
    parameter int TM_B2   = 16,
    parameter int MIN_DIV = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    output logic [3:0] wave,
    output logic [3:0] tick
);
    localparam int MIN_W = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_DIV - 1);

    logic [PRE_W-1:0] cnt;
    logic [MIN_W-1:0] mcnt;

    function automatic int out_bit(input int g);
        case (g)
            0:       return 0;
            1:       return CO_B1;
            2:       return CO_B2;
            default: return CO_B3;
        endcase
    endfunction

    function automatic int tap_bit(input int g);
        case (g)
            0:       return TM_B0;
            1:       return TM_B1;
            default: return TM_B2;
        endcase
    endfunction

    // Half-period counter: bit k toggles every 2^k strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (ref_tick) cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < 4; g++) begin : g_wave
        assign wave[g] = cnt[out_bit(g)];
    end

    // A tap fires on the strobe that rolls its low bits over.
    for (genvar g = 0; g < 3; g++) begin : g_tap
        localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << tap_bit(g)) - 64'd1);
        assign tick[g] = ref_tick && ((cnt & MASK) == MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mcnt <= '0;
        else if (tick[2]) mcnt <= (mcnt == MIN_LAST) ? '0 : mcnt + 1'b1;
    end

    assign tick[3] = tick[2] && (mcnt == MIN_LAST);
endmodule

// File: rtl/rtcdiv_clkgate.sv
module rtcdiv_clkgate
    import rtcdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] req_sel,
    input  logic [3:0] wave,
    output logic       clk_out,
    output logic [1:0] cur_sel
);
    co_state_e  state, state_n;
    logic [1:0] sel_n;
    logic       old_low, new_low;

    assign old_low = ~wave[cur_sel];
    assign new_low = ~wave[req_sel];

    always_comb begin
        state_n = state;
        sel_n   = cur_sel;
        unique case (state)
            CO_IDLE: begin
                if (en && new_low) begin
                    state_n = CO_RUN;
                    sel_n   = req_sel;
                end
            end
            CO_RUN: begin
                if (!en) begin
                    if (old_low) state_n = CO_IDLE;
                end else if (req_sel != cur_sel) begin
                    state_n = CO_SWAP;
                end
            end
            CO_SWAP: begin
                if (!en) begin
                    if (old_low) state_n = CO_IDLE;
                end else if (old_low && new_low) begin
                    state_n = CO_RUN;
                    sel_n   = req_sel;
                end
            end
            default: state_n = CO_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CO_IDLE;
            cur_sel <= '0;
        end else begin
            state   <= state_n;
            cur_sel <= sel_n;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_out <= 1'b0;
        else        clk_out <= (state != CO_IDLE) && wave[cur_sel];
    end
endmodule

// File: rtl/rtcdiv_countdown.sv
module rtcdiv_countdown
    import rtcdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       src_sel,
    input  logic [3:0]       tick,
    input  logic             load_we,
    input  logic [REG_W-1:0] load_val,
    output logic [REG_W-1:0] count,
    output logic [REG_W-1:0] reload,
    output logic             expire,
    output logic             pulse
);
    logic step;

    assign step   = en && tick[src_sel];
    assign expire = step && (count <= REG_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            reload <= '0;
        end else if (load_we) begin
            count  <= load_val;
            reload <= load_val;
        end else if (step) begin
            count  <= expire ? reload : count - 1'b1;
        end
    end

    // Pulse lasts from an expiry to the next source tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pulse <= 1'b0;
        else if (!en)  pulse <= 1'b0;
        else if (step) pulse <= expire;
    end
endmodule

// File: rtl/rtcdiv_timer.sv
module rtcdiv_timer
    import rtcdiv_pkg::*;
#(
    parameter int PRE_W   = 16,
    parameter int CO_B1   = 5,
    parameter int CO_B2   = 10,
    parameter int CO_B3   = 15,
    parameter int TM_B0   = 4,
    parameter int TM_B1   = 10,
    parameter int TM_B2   = 16,
    parameter int MIN_DIV = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              clk_out,
    output logic              irq_n
);
    logic [3:0]       wave, tick;
    logic             co_en_q, tm_en_q, tie_q, pulse_q, tf_q;
    logic [1:0]       co_sel_q, tm_sel_q, cur_sel;
    logic             ctrl_we, clko_we, tctl_we, tcnt_we;
    logic [REG_W-1:0] cd_count, cd_reload;
    logic             cd_expire, cd_pulse;

    assign ctrl_we = wr_en && (wr_addr == A_CTRL);
    assign clko_we = wr_en && (wr_addr == A_CLKO);
    assign tctl_we = wr_en && (wr_addr == A_TCTL);
    assign tcnt_we = wr_en && (wr_addr == A_TCNT);

    rtcdiv_prescale #(
        .PRE_W(PRE_W), .CO_B1(CO_B1), .CO_B2(CO_B2), .CO_B3(CO_B3),
        .TM_B0(TM_B0), .TM_B1(TM_B1), .TM_B2(TM_B2), .MIN_DIV(MIN_DIV)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wave(wave), .tick(tick)
    );

    rtcdiv_clkgate u_gate (
        .clk(clk), .rst_n(rst_n), .en(co_en_q), .req_sel(co_sel_q),
        .wave(wave), .clk_out(clk_out), .cur_sel(cur_sel)
    );

    rtcdiv_countdown u_cd (
        .clk(clk), .rst_n(rst_n), .en(tm_en_q), .src_sel(tm_sel_q), .tick(tick),
        .load_we(tcnt_we), .load_val(wr_data), .count(cd_count),
        .reload(cd_reload), .expire(cd_expire), .pulse(cd_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            co_en_q  <= 1'b0;
            co_sel_q <= '0;
            tm_en_q  <= 1'b0;
            tm_sel_q <= '0;
            tie_q    <= 1'b0;
            pulse_q  <= 1'b0;
            tf_q     <= 1'b0;
        end else begin
            if (clko_we) begin
                co_en_q  <= wr_data[EN_BIT];
                co_sel_q <= wr_data[1:0];
            end
            if (tctl_we) begin
                tm_en_q  <= wr_data[EN_BIT];
                tm_sel_q <= wr_data[1:0];
            end
            if (ctrl_we) begin
                tie_q   <= wr_data[TIE_BIT];
                pulse_q <= wr_data[PULSE_BIT];
            end
            if (cd_expire)                        tf_q <= 1'b1;
            else if (ctrl_we && !wr_data[TF_BIT]) tf_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[PULSE_BIT] = pulse_q;
                rd_data[TF_BIT]    = tf_q;
                rd_data[TIE_BIT]   = tie_q;
            end
            A_CLKO: begin
                rd_data[EN_BIT] = co_en_q;
                rd_data[1:0]    = co_sel_q;
            end
            A_TCTL: begin
                rd_data[EN_BIT] = tm_en_q;
                rd_data[1:0]    = tm_sel_q;
            end
            A_TCNT:  rd_data = cd_count;
            default: rd_data = '0;
        endcase
    end

    assign irq_n = ~(tie_q & (pulse_q ? cd_pulse : tf_q));
endmodule

// File: rtl/rtcdiv_timer_chk.sv
module rtcdiv_timer_chk
    import rtcdiv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             co_en,
    input logic             clk_out,
    input logic [1:0]       cur_sel,
    input logic             tm_en,
    input logic             cnt_we,
    input logic             expire,
    input logic [REG_W-1:0] count,
    input logic [REG_W-1:0] reload,
    input logic             tf
);
    // R3: once disabled for two cycles with the output low, it stays low.
    a_r3_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!co_en && !$past(co_en) && !clk_out) |=> !clk_out);

    // R4: the rate in use changes only while the output is low.
    a_r4_swap_at_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_sel) |-> !clk_out);

    // R6: an expiry reloads the count.
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cnt_we) |=> (count == $past(reload)));

    // R7: an expiry always leaves the flag set.
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tf);

    // R10: a disabled timer keeps its count.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tm_en && !cnt_we) |=> $stable(count));
endmodule

bind rtcdiv_timer rtcdiv_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .co_en(co_en_q), .clk_out(clk_out),
    .cur_sel(cur_sel), .tm_en(tm_en_q), .cnt_we(tcnt_we), .expire(cd_expire),
    .count(cd_count), .reload(cd_reload), .tf(tf_q)
);

// File: tb/rtcdiv_timer_test.sv
module rtcdiv_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       clk_out, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Monitor of high-run lengths on clk_out.
    int allow_a = 0, allow_b = 0, runs = 0, bad_runs = 0, last_run = 0, hi_len = 0;

    always #2 clk = ~clk;

    rtcdiv_timer #(
        .PRE_W(6), .CO_B1(1), .CO_B2(2), .CO_B3(3),
        .TM_B0(1), .TM_B1(2), .TM_B2(3), .MIN_DIV(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .clk_out(clk_out), .irq_n(irq_n)
    );

    always @(negedge clk) begin
        if (clk_out) hi_len++;
        else if (hi_len != 0) begin
            last_run = hi_len;
            runs++;
            if (hi_len != allow_a && hi_len != allow_b) bad_runs++;
            hi_len = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        @(negedge clk);
        rd_addr = a;
        #1 d = int'(rd_data);
    endtask

    task automatic set_allow(input int a, input int b);
        @(negedge clk);
        #1;
        allow_a = a; allow_b = b; runs = 0; bad_runs = 0;
    endtask

    // Waits for a falling edge of irq_n; then reports the low width and the
    // distance to the following falling edge.
    task automatic meas_irq(output int ival, output int low);
        bit prev;
        bit found = 0;
        ival = -1; low = -1;
        @(negedge clk); prev = irq_n;
        for (int i = 0; i < 400 && !found; i++) begin
            @(negedge clk);
            if (prev && !irq_n) found = 1;
            prev = irq_n;
        end
        if (found) begin
            for (int n = 1; n < 400 && ival < 0; n++) begin
                @(negedge clk);
                if (low < 0 && irq_n) low = n;
                if (!prev && irq_n) prev = 1;
                else if (prev && !irq_n) ival = n;
                else prev = irq_n;
            end
        end
    endtask

    task automatic t_reset;
        int v;
        chk(clk_out == 1'b0, "R1 clk_out", int'(clk_out), 0);
        chk(irq_n == 1'b1, "R1 irq_n", int'(irq_n), 1);
        rd(4'h1, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(4'hD, v); chk(v == 0, "R1 clko", v, 0);
        rd(4'hF, v); chk(v == 0, "R1 count", v, 0);
    endtask

    task automatic t_rates;
        for (int k = 0; k < 4; k++) begin
            int half = 1 << k;
            wr(4'hD, 8'h00);
            repeat (40) @(negedge clk);
            set_allow(half, half);
            wr(4'hD, 8'h80 | 8'(k));
            repeat (80) @(negedge clk);
            chk(bad_runs == 0 && last_run == half, "R2 high run length", last_run, half);
            chk(runs >= 3, "R2 output toggles", runs, 3);
        end
    endtask

    task automatic t_disable;
        wr(4'hD, 8'h83);
        repeat (21) @(negedge clk);
        set_allow(8, 8);
        wr(4'hD, 8'h03);
        repeat (20) @(negedge clk);
        chk(bad_runs == 0, "R3 last high phase full", last_run, 8);
        begin
            int highs = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (clk_out) highs++;
            end
            chk(highs == 0, "R3 held low", highs, 0);
        end
    endtask

    task automatic t_swap;
        wr(4'hD, 8'h82);
        repeat (27) @(negedge clk);
        set_allow(4, 1);
        wr(4'hD, 8'h80);
        repeat (30) @(negedge clk);
        chk(bad_runs == 0 && last_run == 1, "R4 swap 4->1", last_run, 1);
        set_allow(1, 8);
        wr(4'hD, 8'h83);
        repeat (60) @(negedge clk);
        chk(bad_runs == 0 && last_run == 8, "R4 swap 1->8", last_run, 8);
        wr(4'hD, 8'h00);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_pulse;
        int ival, low;
        int per [4] = '{2, 4, 8, 24};
        int nval[4] = '{5, 3, 4, 2};
        wr(4'h1, 8'h11);
        for (int k = 0; k < 4; k++) begin
            wr(4'hE, 8'h80 | 8'(k));
            wr(4'hF, 8'(nval[k]));
            meas_irq(ival, low);
            chk(ival == per[k] * nval[k], "R5 R6 expiry interval", ival, per[k] * nval[k]);
            if (k == 0 || k == 3)
                chk(low == per[k], "R8 pulse width", low, per[k]);
        end
    endtask

    task automatic t_level;
        int v;
        bit seen = 0;
        wr(4'hE, 8'h00);
        wr(4'h1, 8'h01);
        rd(4'h1, v); chk(v == 8'h01, "R7 clear by zero", v, 1);
        chk(irq_n == 1'b1, "R9 no flag no irq", int'(irq_n), 1);
        wr(4'hE, 8'h81);
        wr(4'hF, 8'd2);
        rd(4'hE, v); chk(v == 8'h81, "R5 control readback", v, 8'h81);
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (!irq_n) seen = 1;
        end
        chk(seen, "R9 level irq on flag", int'(seen), 1);
        rd(4'h1, v); chk(v == 8'h05, "R7 flag set", v, 5);
        wr(4'hE, 8'h01);
        wr(4'h1, 8'h05);
        rd(4'h1, v); chk(v == 8'h05, "R7 write one keeps flag", v, 5);
        chk(irq_n == 1'b0, "R9 level held", int'(irq_n), 0);
        wr(4'h1, 8'h04);
        rd(4'h1, v); chk(v == 8'h04, "R9 enable off readback", v, 4);
        chk(irq_n == 1'b1, "R9 masked", int'(irq_n), 1);
        wr(4'h1, 8'h00);
        rd(4'h1, v); chk(v == 8'h00, "R7 cleared", v, 0);
    endtask

    task automatic t_hold_load;
        int c1, c2, v;
        rd(4'hF, c1);
        repeat (60) @(negedge clk);
        rd(4'hF, c2);
        chk(c1 == c2, "R10 count held", c2, c1);
        rd(4'h1, v); chk(v == 0, "R10 no expiry", v, 0);
        wr(4'hF, 8'd200);
        rd(4'hF, v); chk(v == 200, "R6 load readback", v, 200);
        wr(4'hE, 8'h80);
        repeat (20) @(negedge clk);
        rd(4'hF, v);
        chk(v >= 186 && v <= 196, "R6 live count decrements", v, 190);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_rates();
        t_disable();
        t_swap();
        t_pulse();
        t_level();
        t_hold_load();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule